// File: doc/BRIEF.md
# Eight-Channel Edge-Aligned PWM Timer

This block is a PWM timer in which a group of output channels (eight by default) share a single up-counter. The counter advances on a selectable tick and divides that tick by a power-of-two prescaler. The tick can be every system clock, or a one-cycle enable pulse from a fixed-rate input or an external input. The counter runs from a programmable start count up to a programmable wrap value and then reloads, so every channel has the same period. Each channel compares the live count with its own compare register. The result is an edge-aligned pulse that is active from the start of the period until the count reaches the compare value. Per channel, an invert bit can be applied, and a gate bit can force the pin to a programmed idle level.

A host programs the block through one 32-bit request/response port built on valid/ready handshakes. A request carries an 8-bit byte address, a write flag and write data. It is accepted on a cycle in which `req_valid` and `req_ready` are both high. Writes produce no response. A read produces exactly one response on the cycle after acceptance. The response stays on `rsp_rdata` with `rsp_valid` high until the host raises `rsp_ready`. While a response is pending, `req_ready` is held low, so back-pressure on the response side stalls the request side. The wrap value and the compare values are double-buffered, so a host may rewrite them at any time without producing a truncated pulse.

Top module: `pwm_timer8`

## Requirements
- R1: After reset, every channel is gated, the gate register reads 0xFF, all other registers and the live count read 0, and every `pwm_out` bit is 0.
- R2: Register byte addresses are as follows. Control is at 0x00. The live count is at 0x04. The wrap value is at 0x08. The start count is at 0x4C. The idle levels are at 0x5C. The gates are at 0x60. The invert bits are at 0x70. Channel n has its mode register at 0x0C+8n and its compare register at 0x10+8n. An unmapped address reads 0. A mode register keeps only bits 5 and 3.
- R3: Control bits [4:3] select the tick. 0 halts the counter, 1 selects every clock, 2 selects `fix_tick` pulses and 3 selects `ext_tick` pulses.
- R4: Control bits [2:0] hold an exponent PS. The counter advances once per 2^PS selected ticks.
- R5: The counter steps by one from the start count up to the wrap value, then reloads the start count. A period is therefore wrap − start + 1 counts.
- R6: A channel whose mode register has bits 5 and 3 both set drives the active level while count < compare and the inactive level otherwise. Any other mode value gives a constant inactive level. The active level is 1 when not inverted.
- R7: A compare value of 0 gives a constant inactive output. A compare value above the wrap value gives a constant active output.
- R8: Invert bit n swaps the active and inactive levels of channel n.
- R9: When gate bit n is set, `pwm_out[n]` equals idle bit n, whatever the invert bit and the count are.
- R10: A written wrap or compare value goes live only at the next counter reload. While the counter is halted, it goes live one cycle after the write.
- R11: A read of the count address returns the live count. A write to it loads the start count and restarts the prescaler.
- R12: A read accepted in cycle t raises `rsp_valid` in cycle t+1. A write never raises it. `rsp_rdata` and `rsp_valid` hold while `rsp_ready` is low, and `req_ready` stays low until the response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fix_tick | input | 1 | One-cycle enable pulses from the fixed-rate source |
| ext_tick | input | 1 | One-cycle enable pulses from the external source |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 32 | Read data |
| pwm_out | output | NCH | Channel outputs |

## Verification
The bound assertions check the following on every cycle:
- the response handshake holds its data and valid under back-pressure, and a read always yields a response;
- the count stays frozen while halted and otherwise moves only by single steps or by reloads to the start count;
- a count write loads the start count;
- the live wrap and compare values change only on a reload pulse.

Duty cycle and period under each tick source and prescale, and the effect of inversion, gating, extreme compare values and a non-zero start count, can only be shown by the directed scenarios. Those scenarios measure high time and rising edges over whole periods, or step the counter one external pulse at a time.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int PS_W   = 3;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_WRAP  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_START = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_IDLE  = 8'h5C;
  localparam logic [ADDR_W-1:0] OFS_GATE  = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_INV   = 8'h70;
  localparam int CH_BASE   = 12;
  localparam int CH_STRIDE = 8;

  // mode bits that together enable high-true edge-aligned output
  localparam int MODE_BIT_A = 5;
  localparam int MODE_BIT_B = 3;

  typedef enum logic [1:0] {
    SRC_HALT = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_FIX  = 2'd2,
    SRC_EXT  = 2'd3
  } tick_src_e;

  typedef struct packed {
    tick_src_e       src;
    logic [PS_W-1:0] ps;
  } ctrl_t;

  function automatic logic [ADDR_W-1:0] ch_mode_ofs(input int n);
    return ADDR_W'(CH_BASE + CH_STRIDE * n);
  endfunction

  function automatic logic [ADDR_W-1:0] ch_cmp_ofs(input int n);
    return ADDR_W'(CH_BASE + CH_STRIDE * n + 4);
  endfunction
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_timer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  tick_src_e       src,
  input  logic [PS_W-1:0] ps,
  input  logic            fix_tick,
  input  logic            ext_tick,
  input  logic            restart,
  output logic            adv
);
  localparam int PRE_W = (1 << PS_W) - 1;

  logic             tick;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;
  logic             at_limit;

  always_comb begin
    case (src)
      SRC_SYS: tick = 1'b1;
      SRC_FIX: tick = fix_tick;
      SRC_EXT: tick = ext_tick;
      default: tick = 1'b0;
    endcase
  end

  assign limit    = PRE_W'((32'd1 << ps) - 32'd1);
  assign at_limit = (pre_q >= limit);
  assign adv      = tick && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pre_q <= '0;
    else if (restart)    pre_q <= '0;
    else if (tick)       pre_q <= at_limit ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halted,
  input  logic          adv,
  input  logic          cnt_wr,
  input  logic [CW-1:0] start,
  input  logic [CW-1:0] wrap_in,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] wrap_act,
  output logic          ld
);
  logic at_end;

  assign at_end = (cnt >= wrap_act);
  // shadow transfer pulse: period boundary, or continuously while halted
  assign ld     = halted || (adv && at_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      wrap_act <= '0;
    end else begin
      if (cnt_wr)   cnt <= start;
      else if (adv) cnt <= at_end ? start : cnt + 1'b1;
      if (ld)       wrap_act <= wrap_in;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mode,
  input  logic              wr_cmp,
  input  logic [1:0]        mode_in,
  input  logic [CW-1:0]     cmp_in,
  input  logic              ld,
  input  logic [CW-1:0]     cnt,
  input  logic              invert,
  input  logic              gate,
  input  logic              idle,
  output logic              out,
  output logic [DATA_W-1:0] mode_word,
  output logic [CW-1:0]     cmp_sh,
  output logic [CW-1:0]     cmp_act
);
  logic [1:0] mode_q;
  logic       pwm_on;
  logic       active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      cmp_sh  <= '0;
      cmp_act <= '0;
    end else begin
      if (wr_mode) mode_q  <= mode_in;
      if (wr_cmp)  cmp_sh  <= cmp_in;
      if (ld)      cmp_act <= cmp_sh;
    end
  end

  assign pwm_on    = &mode_q;
  assign active    = pwm_on && (cnt < cmp_act);
  assign out       = gate ? idle : (active ^ invert);
  assign mode_word = DATA_W'({mode_q[1], 1'b0, mode_q[0], 3'b000});
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwm_timer_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fix_tick,
  input  logic              ext_tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t                       ctrl_q;
  logic [CW-1:0]               start_q;
  logic [CW-1:0]               wrap_sh_q;
  logic [NCH-1:0]              idle_q;
  logic [NCH-1:0]              gate_q;
  logic [NCH-1:0]              inv_q;

  logic                        acc;
  logic                        wr;
  logic                        rd;
  logic                        cnt_wr;
  logic                        adv;
  logic                        ld_w;
  tick_src_e                   src_w;
  logic [CW-1:0]               cnt_w;
  logic [CW-1:0]               wrap_act_w;
  logic [NCH-1:0][CW-1:0]      cmp_sh_w;
  logic [NCH-1:0][CW-1:0]      cmp_act_w;
  logic [NCH-1:0][DATA_W-1:0]  mode_word_w;
  logic [NCH-1:0]              wr_mode;
  logic [NCH-1:0]              wr_cmp;
  logic [DATA_W-1:0]           rd_mux;

  assign req_ready = !rsp_valid;
  assign acc       = req_valid && req_ready;
  assign wr        = acc && req_write;
  assign rd        = acc && !req_write;
  assign cnt_wr    = wr && (req_addr == OFS_COUNT);
  assign src_w     = ctrl_q.src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      start_q   <= '0;
      wrap_sh_q <= '0;
      idle_q    <= '0;
      gate_q    <= '1;
      inv_q     <= '0;
    end else if (wr) begin
      case (req_addr)
        OFS_CTRL:  ctrl_q    <= ctrl_t'(req_wdata[CTRL_W-1:0]);
        OFS_WRAP:  wrap_sh_q <= req_wdata[CW-1:0];
        OFS_START: start_q   <= req_wdata[CW-1:0];
        OFS_IDLE:  idle_q    <= req_wdata[NCH-1:0];
        OFS_GATE:  gate_q    <= req_wdata[NCH-1:0];
        OFS_INV:   inv_q     <= req_wdata[NCH-1:0];
        default: ;
      endcase
    end
  end

  pwm_tick_gen u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (ctrl_q.src),
    .ps       (ctrl_q.ps),
    .fix_tick (fix_tick),
    .ext_tick (ext_tick),
    .restart  (cnt_wr),
    .adv      (adv)
  );

  pwm_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .halted   (ctrl_q.src == SRC_HALT),
    .adv      (adv),
    .cnt_wr   (cnt_wr),
    .start    (start_q),
    .wrap_in  (wrap_sh_q),
    .cnt      (cnt_w),
    .wrap_act (wrap_act_w),
    .ld       (ld_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] MODE_A = ch_mode_ofs(g);
    localparam logic [ADDR_W-1:0] CMP_A  = ch_cmp_ofs(g);

    assign wr_mode[g] = wr && (req_addr == MODE_A);
    assign wr_cmp[g]  = wr && (req_addr == CMP_A);

    pwm_channel #(.CW(CW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_mode   (wr_mode[g]),
      .wr_cmp    (wr_cmp[g]),
      .mode_in   ({req_wdata[MODE_BIT_A], req_wdata[MODE_BIT_B]}),
      .cmp_in    (req_wdata[CW-1:0]),
      .ld        (ld_w),
      .cnt       (cnt_w),
      .invert    (inv_q[g]),
      .gate      (gate_q[g]),
      .idle      (idle_q[g]),
      .out       (pwm_out[g]),
      .mode_word (mode_word_w[g]),
      .cmp_sh    (cmp_sh_w[g]),
      .cmp_act   (cmp_act_w[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (req_addr)
      OFS_CTRL:  rd_mux = DATA_W'(ctrl_q);
      OFS_COUNT: rd_mux = DATA_W'(cnt_w);
      OFS_WRAP:  rd_mux = DATA_W'(wrap_sh_q);
      OFS_START: rd_mux = DATA_W'(start_q);
      OFS_IDLE:  rd_mux = DATA_W'(idle_q);
      OFS_GATE:  rd_mux = DATA_W'(gate_q);
      OFS_INV:   rd_mux = DATA_W'(inv_q);
      default: ;
    endcase
    for (int n = 0; n < NCH; n++) begin
      if (req_addr == ch_mode_ofs(n)) rd_mux = mode_word_w[n];
      if (req_addr == ch_cmp_ofs(n))  rd_mux = DATA_W'(cmp_sh_w[n]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk #(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic [1:0]        src,
  input logic [CW-1:0]     cnt,
  input logic [CW-1:0]     wrap_act,
  input logic [CW-1:0]     start,
  input logic              cnt_wr,
  input logic              ld,
  input logic [NCH*CW-1:0] cmp_act
);
  // R12: response held under back-pressure
  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R12: every accepted read yields a response next cycle
  assert_read_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  // R3: halted counter holds its value
  assert_halt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 2'd0 && !cnt_wr) |=> $stable(cnt));

  // R5: below the wrap value the count moves by at most one
  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && cnt < wrap_act) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  // R5: at the wrap value the count holds or reloads the start count
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && cnt >= wrap_act) |=> (cnt == $past(cnt) || cnt == $past(start)));

  // R11: a count write loads the start count
  assert_cnt_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(start)));

  // R10: live compare and wrap values change only on a transfer pulse
  assert_cmp_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_act) |-> $past(ld));

  assert_wrap_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wrap_act) |-> $past(ld));
endmodule

bind pwm_timer8 pwm_timer8_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .src       (src_w),
  .cnt       (cnt_w),
  .wrap_act  (wrap_act_w),
  .start     (start_q),
  .cnt_wr    (cnt_wr),
  .ld        (ld_w),
  .cmp_act   (cmp_act_w)
);

// File: tb/pwm_timer8_test.sv
module pwm_timer8_test;
  localparam int CLK_NS = 10;
  localparam int NCH = 8;
  localparam int CW  = 16;

  localparam logic [7:0] A_CTRL = 8'h00, A_COUNT = 8'h04, A_WRAP = 8'h08;
  localparam logic [7:0] A_START = 8'h4C, A_IDLE = 8'h5C, A_GATE = 8'h60, A_INV = 8'h70;
  localparam logic [7:0] A_MODE0 = 8'h0C, A_CMP0 = 8'h10, A_MODE1 = 8'h14;
  localparam logic [7:0] A_MODE3 = 8'h24, A_CMP3 = 8'h28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fix_tick = 1'b0;
  logic ext_tick = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [NCH-1:0] pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  logic fix_en = 1'b0;
  int fix_div = 0;

  always #(CLK_NS/2) clk = ~clk;

  // fixed-rate source: one pulse every third clock
  always @(negedge clk) begin
    if (fix_en) begin
      fix_div  <= (fix_div == 2) ? 0 : fix_div + 1;
      fix_tick <= (fix_div == 2);
    end else begin
      fix_div  <= 0;
      fix_tick <= 1'b0;
    end
  end

  pwm_timer8 #(.NCH(NCH), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .fix_tick(fix_tick), .ext_tick(ext_tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_rdata;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_tick = 1'b1;
      @(negedge clk); ext_tick = 1'b0;
    end
  endtask

  task automatic sample_ch(input int ch, input int ncyc, output int highs, output int rises);
    logic prev;
    highs = 0; rises = 0;
    @(negedge clk);
    prev = pwm_out[ch];
    for (int i = 0; i < ncyc; i++) begin
      if (prev) highs++;
      @(negedge clk);
      if (!prev && pwm_out[ch]) rises++;
      prev = pwm_out[ch];
    end
  endtask

  task automatic setup(input int wrapv, input int startv, input int cmpv,
                       input int src, input int ps, input logic [7:0] inv);
    wr(A_CTRL, 32'h0);
    wr(A_WRAP, 32'(wrapv));
    wr(A_START, 32'(startv));
    wr(A_MODE0, 32'h28);
    wr(A_CMP0, 32'(cmpv));
    wr(A_INV, 32'(inv));
    wr(A_IDLE, 32'h0);
    wr(A_GATE, 32'hFE);
    wr(A_COUNT, 32'h0);
    repeat (2) @(negedge clk);
    wr(A_CTRL, 32'((src << 3) | ps));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1", "pwm_out after reset", 32'(pwm_out), 32'h0);
    rd(A_GATE, d);  chk("R1", "gate reset", d, 32'hFF);
    rd(A_COUNT, d); chk("R1", "count reset", d, 32'h0);
    rd(A_CTRL, d);  chk("R1", "ctrl reset", d, 32'h0);
    rd(A_WRAP, d);  chk("R1", "wrap reset", d, 32'h0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr(A_CMP3, 32'h1234); rd(A_CMP3, d); chk("R2", "ch3 compare readback", d, 32'h1234);
    wr(A_MODE3, 32'hFF);  rd(A_MODE3, d); chk("R2", "ch3 mode keeps bits 5,3", d, 32'h28);
    wr(A_INV, 32'hA5);    rd(A_INV, d);   chk("R2", "invert readback", d, 32'hA5);
    rd(8'h50, d); chk("R2", "unmapped read", d, 32'h0);
    wr(A_INV, 32'h0);
  endtask

  task automatic t_basic;
    int h, r;
    setup(9, 0, 4, 1, 0, 8'h00);
    sample_ch(0, 100, h, r);
    chk("R6", "high cycles 4/10", 32'(h), 32'd40);
    chk("R5", "periods of 10 in 100", 32'(r), 32'd10);
    sample_ch(1, 50, h, r);
    chk("R6", "gated channel with mode 0 low", 32'(h), 32'd0);
  endtask

  task automatic t_prescale;
    int h, r;
    setup(9, 0, 4, 1, 2, 8'h00);
    sample_ch(0, 400, h, r);
    chk("R4", "PS=2 high cycles", 32'(h), 32'd160);
    chk("R4", "PS=2 period count", 32'(r), 32'd10);
  endtask

  task automatic t_fixsrc;
    int h, r;
    fix_en = 1'b1;
    setup(9, 0, 4, 2, 1, 8'h00);
    sample_ch(0, 600, h, r);
    chk("R3", "fixed source PS=1 high cycles", 32'(h), 32'd240);
    chk("R3", "fixed source period count", 32'(r), 32'd10);
    fix_en = 1'b0;
  endtask

  task automatic t_polarity;
    int h, r;
    setup(9, 0, 4, 1, 0, 8'h01);
    sample_ch(0, 100, h, r);
    chk("R8", "inverted high cycles", 32'(h), 32'd60);
  endtask

  task automatic t_mask;
    int h, r;
    setup(9, 0, 4, 1, 0, 8'h03);
    wr(A_MODE1, 32'h0);
    wr(A_GATE, 32'hFC);
    sample_ch(1, 50, h, r);
    chk("R6", "mode-off channel inverted constant", 32'(h), 32'd50);
    wr(A_IDLE, 32'h01);
    wr(A_GATE, 32'hFF);
    sample_ch(0, 50, h, r);
    chk("R9", "gated idle=1", 32'(h), 32'd50);
    wr(A_IDLE, 32'h00);
    sample_ch(0, 50, h, r);
    chk("R9", "gated idle=0", 32'(h), 32'd0);
  endtask

  task automatic t_extremes;
    int h, r;
    setup(9, 0, 0, 1, 0, 8'h00);
    sample_ch(0, 100, h, r);
    chk("R7", "compare 0 constant low", 32'(h), 32'd0);
    setup(9, 0, 15, 1, 0, 8'h00);
    sample_ch(0, 100, h, r);
    chk("R7", "compare above wrap constant high", 32'(h), 32'd100);
  endtask

  task automatic t_start;
    int h, r;
    setup(9, 6, 8, 1, 0, 8'h00);
    sample_ch(0, 100, h, r);
    chk("R5", "start 6 high cycles", 32'(h), 32'd50);
    chk("R5", "start 6 period count", 32'(r), 32'd25);
  endtask

  task automatic t_buffered;
    logic [31:0] d;
    setup(9, 0, 4, 3, 0, 8'h00);
    step(3);
    rd(A_COUNT, d); chk("R11", "live count after 3 steps", d, 32'd3);
    chk("R6", "out high at count 3", 32'(pwm_out[0]), 32'd1);
    wr(A_CMP0, 32'd2);
    @(negedge clk);
    chk("R10", "new compare not yet live", 32'(pwm_out[0]), 32'd1);
    step(1);
    chk("R6", "out low at count 4", 32'(pwm_out[0]), 32'd0);
    wr(A_WRAP, 32'd5);
    step(5);
    rd(A_COUNT, d); chk("R10", "old wrap still live", d, 32'd9);
    step(1);
    rd(A_COUNT, d); chk("R5", "reload to start", d, 32'd0);
    chk("R10", "out high after reload", 32'(pwm_out[0]), 32'd1);
    step(2);
    chk("R10", "new compare live at count 2", 32'(pwm_out[0]), 32'd0);
    step(4);
    rd(A_COUNT, d); chk("R10", "new wrap live", d, 32'd0);
    step(3);
    wr(A_START, 32'd1);
    wr(A_COUNT, 32'd0);
    rd(A_COUNT, d); chk("R11", "count write loads start", d, 32'd1);
  endtask

  task automatic t_halt;
    logic [31:0] a, b;
    setup(9, 0, 4, 1, 0, 8'h00);
    repeat (7) @(negedge clk);
    wr(A_CTRL, 32'h0);
    rd(A_COUNT, a);
    repeat (20) @(negedge clk);
    rd(A_COUNT, b);
    chk("R3", "halted count frozen", b, a);
  endtask

  task automatic t_backpressure;
    wr(A_GATE, 32'hFE);
    @(negedge clk);
    chk("R12", "write gives no response", 32'(rsp_valid), 32'd0);
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = A_GATE;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12", "response next cycle", 32'(rsp_valid), 32'd1);
    chk("R12", "request blocked while pending", 32'(req_ready), 32'd0);
    repeat (3) @(negedge clk);
    chk("R12", "response held", 32'(rsp_valid), 32'd1);
    chk("R12", "data held", rsp_rdata, 32'hFE);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R12", "response taken", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_basic();
    t_prescale();
    t_fixsrc();
    t_polarity();
    t_mask();
    t_extremes();
    t_start();
    t_buffered();
    t_halt();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule